// File: doc/BRIEF.md
# Instruction Stream Buffer Miss Handler

This block services misses from a level-0 instruction cache. It keeps a one-line stream buffer. The buffer holds the line that sequentially follows the most recent fetch. A new miss is compared with that buffer before any request goes to L2.

On a buffer hit, the block returns the requested 8-byte word to the CPU. One cycle later it writes the whole 32-byte line into the L0 cache. On a buffer miss, it requests the line from L2 with the 16-byte half that holds the requested word first. It answers the CPU as soon as that half arrives, and it fills L0 once the other half has landed.

Every completed miss, whether served from the buffer or from L2, is followed by a prefetch of the next sequential line into the buffer. A new miss is not accepted while that prefetch is outstanding, so the miss is checked against the refreshed buffer. A flush input clears the buffer and discards a prefetch that is still returning data.

Top module: `ifetch_stream_ctrl`

## Requirements
- R1: After reset `miss_ready_o` is 1, and `rsp_valid_o`, `fill_valid_o` and `l2_req_valid_o` are 0.
- R2: A miss to the line held in a valid buffer makes no L2 request. The response arrives in the second cycle after the miss is accepted.
- R3: On a buffer hit, `fill_valid_o` is high in the cycle after the response. It carries the 32-byte-aligned line address and the full line. Response and fill are never valid in the same cycle.
- R4: A miss that does not hit the buffer issues exactly one L2 request. Its address is the miss address with bits [3:0] cleared, so bit 4 selects the critical half. The first returned beat is that half and the second beat is the other half.
- R5: The CPU response carries the 8 bytes at line offset 8*k, where k is miss address bits [4:3]. Byte order is little-endian: lowest address in bits [7:0]. On an L2 fill the response is valid in the cycle after the first beat.
- R6: After an L2 fill, `fill_valid_o` is high two cycles after the second beat. Its data is laid out in address order: bits [64k+63:64k] hold bytes 8k to 8k+7.
- R7: `miss_ready_o` is high only when no operation or prefetch is in progress, and a miss is taken only when it is high. A miss raised during a prefetch waits, then is served from the refreshed buffer.
- R8: After each fill to L0, the block requests the next sequential line: the line base plus 32, with bits [4:0] zero. Once that data has arrived, a miss to that line hits the buffer.
- R9: A flush with no prefetch in flight invalidates the buffer, so the next miss to the buffered line goes to L2.
- R10: A flush while a prefetch is requested or returning causes its data to be discarded, so a later miss to that line goes to L2.
- R11: `l2_req_valid_o` stays high with an unchanged address until `l2_req_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate the stream buffer and drop any prefetch in flight |
| miss_valid_i | input | 1 | L0 miss request |
| miss_addr_i | input | ADDR_W | Byte address of the missing fetch |
| miss_ready_o | output | 1 | Miss accepted when high together with miss_valid_i |
| rsp_valid_o | output | 1 | CPU word valid |
| rsp_data_o | output | WORD_W | Requested 8-byte word |
| fill_valid_o | output | 1 | L0 line write strobe |
| fill_addr_o | output | ADDR_W | Line-aligned fill address |
| fill_data_o | output | 2*BEAT_W | Full line in address order |
| l2_req_valid_o | output | 1 | L2 read request |
| l2_req_ready_i | input | 1 | L2 accepts the request |
| l2_req_addr_o | output | ADDR_W | 16-byte-aligned address of the first beat wanted |
| l2_rsp_valid_i | input | 1 | L2 beat valid |
| l2_rsp_data_i | input | BEAT_W | 16-byte beat |

## Verification
The hardest case to reach is a miss that arrives while the prefetch triggered by the previous miss is still outstanding. It must stall and then hit the freshly written buffer. The stimulus reaches this by raising the next sequential miss the moment the prefetch request is seen. The sweep covers every critical word, L2 latency and inter-beat gap. A second hard case is a flush that lands between prefetch issue and data return. It is forced by pulsing flush in the cycle right after the prefetch request is taken, then missing to that line.

// File: rtl/isb_pkg.sv
`timescale 1ns/1ps
package isb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOOK, ST_HIT_RSP, ST_HIT_FILL,
    ST_DM_REQ, ST_DM_B0, ST_DM_CRIT, ST_DM_B1, ST_DM_FILL,
    ST_PF_REQ, ST_PF_WAIT
  } isb_state_e;
endpackage

// File: rtl/isb_stream_buf.sv
`timescale 1ns/1ps
module isb_stream_buf #(
  parameter int LA_W   = 27,
  parameter int LINE_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inval_i,
  input  logic              wr_i,
  input  logic [LA_W-1:0]   wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [LA_W-1:0]   look_tag_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o
);
  logic              valid_q;
  logic [LA_W-1:0]   tag_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      line_q  <= '0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      tag_q   <= wr_tag_i;
      line_q  <= wr_line_i;
    end else if (inval_i) begin
      valid_q <= 1'b0;
    end
  end

  assign hit_o  = valid_q && (tag_q == look_tag_i);
  assign line_o = line_q;
endmodule

// File: rtl/isb_beat_asm.sv
`timescale 1ns/1ps
module isb_beat_asm #(
  parameter int BEAT_W = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                first_half_i,
  input  logic                beat_valid_i,
  input  logic [BEAT_W-1:0]   beat_data_i,
  output logic [2*BEAT_W-1:0] line_o,
  output logic                full_o
);
  logic [2*BEAT_W-1:0] line_q;
  logic [1:0]          cnt_q;
  logic                half_q;

  assign full_o = (cnt_q == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      cnt_q  <= 2'd0;
      half_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= 2'd0;
      half_q <= first_half_i;
    end else if (beat_valid_i && !full_o) begin
      if (half_q) line_q[2*BEAT_W-1:BEAT_W] <= beat_data_i;
      else        line_q[BEAT_W-1:0]        <= beat_data_i;
      half_q <= ~half_q;  // wrap to the other half
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/ifetch_stream_ctrl.sv
`timescale 1ns/1ps
module ifetch_stream_ctrl
  import isb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 64,
  parameter int BEAT_W = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                miss_valid_i,
  input  logic [ADDR_W-1:0]   miss_addr_i,
  output logic                miss_ready_o,
  output logic                rsp_valid_o,
  output logic [WORD_W-1:0]   rsp_data_o,
  output logic                fill_valid_o,
  output logic [ADDR_W-1:0]   fill_addr_o,
  output logic [2*BEAT_W-1:0] fill_data_o,
  output logic                l2_req_valid_o,
  input  logic                l2_req_ready_i,
  output logic [ADDR_W-1:0]   l2_req_addr_o,
  input  logic                l2_rsp_valid_i,
  input  logic [BEAT_W-1:0]   l2_rsp_data_i
);
  localparam int LINE_W = 2 * BEAT_W;
  localparam int OFF_W  = $clog2(LINE_W / 8);
  localparam int WOFF_W = $clog2(WORD_W / 8);
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int RQ_W   = ADDR_W - WOFF_W;

  isb_state_e        state_q, state_d;
  logic [RQ_W-1:0]   req_q;
  logic [LA_W-1:0]   pf_line_q;
  logic              drop_q;

  logic [LA_W-1:0]   req_line;
  logic              req_crit;
  logic [WSEL_W-1:0] req_wsel;
  logic              sb_hit, sb_wr, sb_inval;
  logic [LINE_W-1:0] sb_line, asm_line, rsp_line;
  logic              asm_full, asm_start;

  assign req_line = req_q[RQ_W-1:OFF_W-WOFF_W];
  assign req_crit = req_q[OFF_W-1-WOFF_W];
  assign req_wsel = req_q[OFF_W-WOFF_W-1:0];

  isb_stream_buf #(.LA_W(LA_W), .LINE_W(LINE_W)) u_sbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inval_i    (sb_inval),
    .wr_i       (sb_wr),
    .wr_tag_i   (pf_line_q),
    .wr_line_i  (asm_line),
    .look_tag_i (req_line),
    .hit_o      (sb_hit),
    .line_o     (sb_line)
  );

  isb_beat_asm #(.BEAT_W(BEAT_W)) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (asm_start),
    .first_half_i ((state_q == ST_DM_REQ) ? req_crit : 1'b0),
    .beat_valid_i (l2_rsp_valid_i),
    .beat_data_i  (l2_rsp_data_i),
    .line_o       (asm_line),
    .full_o       (asm_full)
  );

  assign miss_ready_o   = (state_q == ST_IDLE);
  assign l2_req_valid_o = (state_q == ST_DM_REQ) || (state_q == ST_PF_REQ);
  assign l2_req_addr_o  = (state_q == ST_DM_REQ) ? {req_line, req_crit, {(OFF_W-1){1'b0}}}
                                                 : {pf_line_q, {OFF_W{1'b0}}};
  assign asm_start      = l2_req_valid_o && l2_req_ready_i;

  assign rsp_valid_o  = (state_q == ST_HIT_RSP) || (state_q == ST_DM_CRIT);
  assign rsp_line     = (state_q == ST_HIT_RSP) ? sb_line : asm_line;
  assign fill_valid_o = (state_q == ST_HIT_FILL) || (state_q == ST_DM_FILL);
  assign fill_data_o  = (state_q == ST_HIT_FILL) ? sb_line : asm_line;
  assign fill_addr_o  = {req_line, {OFF_W{1'b0}}};

  always_comb begin
    rsp_data_o = '0;
    for (int k = 0; k < WORDS; k++)
      if (req_wsel == WSEL_W'(k)) rsp_data_o = rsp_line[k*WORD_W +: WORD_W];
  end

  // buffer line is consumed by a hit; prefetch result dropped after a flush
  assign sb_inval = flush_i || (state_q == ST_HIT_FILL);
  assign sb_wr    = (state_q == ST_PF_WAIT) && asm_full && !drop_q && !flush_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (miss_valid_i) state_d = ST_LOOK;
      ST_LOOK:     state_d = sb_hit ? ST_HIT_RSP : ST_DM_REQ;
      ST_HIT_RSP:  state_d = ST_HIT_FILL;
      ST_HIT_FILL: state_d = ST_PF_REQ;
      ST_DM_REQ:   if (l2_req_ready_i) state_d = ST_DM_B0;
      ST_DM_B0:    if (l2_rsp_valid_i) state_d = ST_DM_CRIT;
      ST_DM_CRIT:  state_d = ST_DM_B1;
      ST_DM_B1:    if (asm_full) state_d = ST_DM_FILL;
      ST_DM_FILL:  state_d = ST_PF_REQ;
      ST_PF_REQ:   if (l2_req_ready_i) state_d = ST_PF_WAIT;
      ST_PF_WAIT:  if (asm_full) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      req_q     <= '0;
      pf_line_q <= '0;
      drop_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && miss_valid_i) req_q <= miss_addr_i[ADDR_W-1:WOFF_W];
      if (state_q == ST_HIT_FILL || state_q == ST_DM_FILL) begin
        pf_line_q <= req_line + LA_W'(1);
        drop_q    <= 1'b0;
      end else if (flush_i && (state_q == ST_PF_REQ || state_q == ST_PF_WAIT)) begin
        drop_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isb_checker.sv
`timescale 1ns/1ps
module isb_checker #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic              rsp_valid_o,
  input logic              fill_valid_o,
  input logic [ADDR_W-1:0] fill_addr_o,
  input logic              l2_req_valid_o,
  input logic              l2_req_ready_i,
  input logic [ADDR_W-1:0] l2_req_addr_o
);
  localparam int OFF_W = $clog2(2 * BEAT_W / 8);

  AST_RSP_FILL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && fill_valid_o)); // R3

  AST_FILL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> (fill_addr_o == ((fill_addr_o >> OFF_W) << OFF_W))); // R3

  AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_valid_o |-> (l2_req_addr_o == ((l2_req_addr_o >> (OFF_W-1)) << (OFF_W-1)))); // R4

  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ready_o |-> !(rsp_valid_o || fill_valid_o || l2_req_valid_o)); // R7

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_o) |=> !miss_ready_o); // R7

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_req_valid_o && !l2_req_ready_i) |=> (l2_req_valid_o && $stable(l2_req_addr_o))); // R11
endmodule

bind ifetch_stream_ctrl isb_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_isb_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .miss_valid_i   (miss_valid_i),
  .miss_ready_o   (miss_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .fill_valid_o   (fill_valid_o),
  .fill_addr_o    (fill_addr_o),
  .l2_req_valid_o (l2_req_valid_o),
  .l2_req_ready_i (l2_req_ready_i),
  .l2_req_addr_o  (l2_req_addr_o)
);

// File: tb/ifetch_stream_ctrl_tb_top.sv
`timescale 1ns/1ps
module ifetch_stream_ctrl_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic         miss_valid_i = 1'b0;
  logic [31:0]  miss_addr_i = '0;
  logic         miss_ready_o;
  logic         rsp_valid_o;
  logic [63:0]  rsp_data_o;
  logic         fill_valid_o;
  logic [31:0]  fill_addr_o;
  logic [255:0] fill_data_o;
  logic         l2_req_valid_o;
  logic         l2_req_ready_i = 1'b0;
  logic [31:0]  l2_req_addr_o;
  logic         l2_rsp_valid_i = 1'b0;
  logic [127:0] l2_rsp_data_i = '0;

  ifetch_stream_ctrl dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0;
  int rsp_cnt = 0, fill_cnt = 0, req_cnt = 0;
  int rsp_cyc, fill_cyc, beat0_cyc, beat1_cyc;
  logic [63:0]  rsp_last;
  logic [31:0]  fill_addr_last, req_addr_last;
  logic [255:0] fill_last;
  int rdly = 0, lat = 1, gap = 1;
  bit done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [63:0] word_of(logic [31:0] a);
    logic [31:0] wa = a >> 3;
    return {wa ^ 32'h5A5A_C3C3, wa};
  endfunction
  function automatic logic [127:0] beat_of(logic [31:0] a);
    return {word_of(a + 32'd8), word_of(a)};
  endfunction
  function automatic logic [255:0] line_of(logic [31:0] a);
    logic [31:0] b = a & ~32'h1F;
    return {beat_of(b + 32'd16), beat_of(b)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    if (rsp_valid_o)  begin rsp_cnt++;  rsp_last = rsp_data_o; rsp_cyc = cyc; end
    if (fill_valid_o) begin fill_cnt++; fill_last = fill_data_o; fill_addr_last = fill_addr_o; fill_cyc = cyc; end
  end

  // L2 model: beat for the requested half first, then the other half
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk_i);
      if (rst_ni && l2_req_valid_o) begin
        a = l2_req_addr_o;
        repeat (rdly) @(negedge clk_i);
        chk(l2_req_valid_o && l2_req_addr_o == a, "R11", l2_req_addr_o, a);
        l2_req_ready_i = 1'b1; req_addr_last = a; req_cnt++;
        @(negedge clk_i); l2_req_ready_i = 1'b0;
        repeat (lat - 1) @(negedge clk_i);
        l2_rsp_valid_i = 1'b1; l2_rsp_data_i = beat_of(a); beat0_cyc = cyc;
        @(negedge clk_i);
        if (gap > 1) begin
          l2_rsp_valid_i = 1'b0;
          repeat (gap - 1) @(negedge clk_i);
        end
        l2_rsp_valid_i = 1'b1; l2_rsp_data_i = beat_of(a ^ 32'h10); beat1_cyc = cyc;
        @(negedge clk_i); l2_rsp_valid_i = 1'b0;
      end
    end
  end

  task automatic do_miss(input logic [31:0] a, input bit exp_hit, input bit exp_wait, input string tag);
    int rb, qb, fb, acc;
    @(negedge clk_i);
    miss_valid_i = 1'b1; miss_addr_i = a;
    if (exp_wait) chk(!miss_ready_o, "R7 stall during prefetch", miss_ready_o, 0);
    while (!miss_ready_o) @(negedge clk_i);
    rb = rsp_cnt; qb = req_cnt; fb = fill_cnt; acc = cyc;
    @(negedge clk_i); miss_valid_i = 1'b0;
    wait (rsp_cnt == rb + 1);
    chk(rsp_last == word_of(a), "R5 word", rsp_last, word_of(a));
    if (exp_hit) begin
      chk(req_cnt == qb, {tag, " no L2 on buffer hit"}, req_cnt, qb);
      chk(rsp_cyc == acc + 2, "R2 hit latency", rsp_cyc, acc + 2);
    end else begin
      chk(req_cnt == qb + 1, {tag, " L2 used on buffer miss"}, req_cnt, qb + 1);
      chk(req_addr_last == (a & ~32'hF), "R4 critical half addr", req_addr_last, a & ~32'hF);
      chk(rsp_cyc == beat0_cyc + 1, "R5 critical first", rsp_cyc, beat0_cyc + 1);
    end
    wait (fill_cnt == fb + 1);
    chk(fill_addr_last == (a & ~32'h1F), "R3 fill addr", fill_addr_last, a & ~32'h1F);
    chk(fill_last == line_of(a), "R6 fill line", fill_last, line_of(a));
    if (exp_hit) chk(fill_cyc == rsp_cyc + 1, "R3 fill after rsp", fill_cyc, rsp_cyc + 1);
    else         chk(fill_cyc == beat1_cyc + 2, "R6 fill timing", fill_cyc, beat1_cyc + 2);
    wait (req_cnt == qb + (exp_hit ? 1 : 2));
    chk(req_addr_last == (a & ~32'h1F) + 32'd32, "R8 next line", req_addr_last, (a & ~32'h1F) + 32'd32);
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (!miss_ready_o) @(negedge clk_i);
  endtask

  task automatic pulse_flush();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
  endtask

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk_i);
    chk(!rsp_valid_o && !fill_valid_o && !l2_req_valid_o, "R1 outputs idle", {rsp_valid_o, fill_valid_o, l2_req_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(miss_ready_o, "R1 ready", miss_ready_o, 1);

    for (int r = 0; r < 2; r++)
      for (int l = 1; l <= 3; l++)
        for (int g = 1; g <= 2; g++)
          for (int w = 0; w < 4; w++) begin
            logic [31:0] base;
            rdly = r; lat = l; gap = g;
            base = 32'(100 + idx * 8) << 5;
            do_miss(base + 32'(w * 8), 1'b0, 1'b0, "R4");
            do_miss(base + 32'd32 + 32'(((w + 1) % 4) * 8), 1'b1, 1'b0, "R2");
            do_miss(base + 32'd64 + 32'(((w + 3) % 4) * 8), 1'b1, 1'b1, "R7");
            idx++;
          end

    // R10: flush while the prefetch is outstanding
    rdly = 0; lat = 2; gap = 1;
    do_miss(32'h0004_0008, 1'b0, 1'b0, "R4");
    pulse_flush();
    wait_idle();
    do_miss(32'h0004_0030, 1'b0, 1'b0, "R10");
    // R9: flush with the buffer holding a completed prefetch
    wait_idle();
    pulse_flush();
    do_miss(32'h0004_0050, 1'b0, 1'b0, "R9");
    wait_idle();
    do_miss(32'h0004_0078, 1'b1, 1'b0, "R8");
    wait_idle();
    finish_sim();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_sim();
  end
endmodule